// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block lets a processor reach PCI configuration space through two register windows. A write to the address window stores a 32-bit word naming a bus, device, function and dword register, plus an enable flag. Later accesses to the data window become configuration cycles on the downstream side. Those cycles carry the bus, device, function, register offset, a type-0/type-1 flag, byte enables, and single-cycle read and write strobes. A presence flag and read data come back from the downstream side.

The processor side is big-endian, so data is byte-swapped on its way through. The low two bits of the data-window address choose a starting byte inside the selected dword, and that choice wraps within the dword. Writes narrower than a dword, and writes that do not start at byte 0, are done as a read-modify-write. A request is held by the processor until the one-cycle `cpu_ready` pulse arrives.

A five-state machine runs each access. IDLE accepts a request. READ drives the read strobe. CAPTURE takes the returned dword and either formats the read result or merges the write bytes. WRITE drives the write strobe. DONE pulses ready. The transitions are:
- IDLE to DONE for address-window accesses, for data-window accesses while the enable flag is clear, and for absent devices.
- IDLE to WRITE for an aligned four-byte write.
- IDLE to READ for every other data access.
- READ to CAPTURE, always.
- CAPTURE to WRITE for writes, and CAPTURE to DONE for reads.
- WRITE to DONE, and DONE to IDLE, always.

Top module: `cfg_access_bridge`

## Requirements
- R1: An address-window write (`cpu_data_sel`=0) stores all 32 bits of `cpu_wdata` in the address word, and an address-window read returns the stored word unchanged.
- R2: When bit 7 of the address word (enable) is 0, a data-window read returns 0 and a data-window write is dropped; neither raises `cfg_rd` or `cfg_wr`.
- R3: The configuration fields are taken from the address word as follows: bus from bits 15:8, device from bits 23:19, function from bits 18:16, and register offset from bits 31:24 with bits 1:0 forced to 0.
- R4: `cfg_type1` is 0 when the bus number is zero and 1 for any other bus number.
- R5: A data-window read to an absent device (`cfg_present`=0) returns 0xFFFFFFFF without raising `cfg_rd`.
- R6: A data read returns bytes D[k], D[k+1], ... (index mod 4) of the device dword, where k = `cpu_offset` and D[0] is bits 7:0. The first byte is placed most significant. `cpu_size` 0 gives 1 byte in bits 7:0, 1 gives 2 bytes in bits 15:0, and 2 or 3 gives 4 bytes. Unused upper bits are 0.
- R7: A four-byte write (`cpu_size` 2 or 3) at `cpu_offset` 0 raises `cfg_wr` one cycle after acceptance, without a prior read, carrying `cpu_wdata` byte-reversed.
- R8: Every other write first reads the dword and then writes it back with the new bytes merged in. The most significant written CPU byte goes to device lane k and the next to lane k+1 (mod 4). `cfg_be` marks the changed lanes during `cfg_wr`, and is 4'b1111 otherwise.
- R9: Latencies count from the accepting edge to the `cpu_ready` pulse. An enabled read of a present device takes 3 cycles. A read-modify-write takes 4 cycles, with `cfg_rd` in cycle 1 and `cfg_wr` in cycle 3. An aligned write takes 2 cycles. Every other access takes 1 cycle. `cpu_ready` is high for exactly one cycle.
- R10: A write to an absent device ends with `cpu_ready` and raises neither `cfg_rd` nor `cfg_wr`.
- R11: After reset the address word is 0 and `cpu_ready`, `cfg_rd` and `cfg_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_data_sel | input | 1 | 0 selects the address window, 1 the data window |
| cpu_write | input | 1 | 1 for a write, 0 for a read |
| cpu_offset | input | 2 | Starting byte within the dword (data window) |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| cpu_wdata | input | 32 | Write data, big-endian |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 8 | Dword-aligned register offset |
| cfg_be | output | 4 | Byte enables, lane 0 = bits 7:0 |
| cfg_type1 | output | 1 | 1 for a type-1 cycle |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_wdata | output | 32 | Configuration write data, little-endian |
| cfg_present | input | 1 | Addressed device exists |
| cfg_rdata | input | 32 | Read data, valid the cycle after `cfg_rd` |

## Verification
The assertions check the following on every cycle:
- the two strobes are never high together;
- ready lasts one cycle;
- no write strobe appears unless the enable bit is set and the device is present;
- an aligned write strobes in the cycle after it is accepted;
- a read-modify-write always follows its read strobe with a write strobe two cycles later;
- the address word changes only when it is loaded.

The byte steering, the wrap across the dword, the merged write-back values, the absent-device value and the field positions are value-dependent, and only the bench's scenarios show them. The bench compares them against its behavioural model of the processor view and of the target's storage.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    localparam int unsigned DWORD_W     = 32;
    localparam int unsigned LANES       = DWORD_W / 8;
    localparam int unsigned OFF_W       = $clog2(LANES);
    localparam int unsigned EN_BIT      = 7;
    localparam int unsigned BUS_LSB     = 8;
    localparam int unsigned BUS_W       = 8;
    localparam int unsigned FN_LSB      = 16;
    localparam int unsigned FN_W        = 3;
    localparam int unsigned DEV_LSB     = 19;
    localparam int unsigned DEV_W       = 5;
    localparam int unsigned REG_LSB     = 24;
    localparam int unsigned REG_W       = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPTURE,
        ST_WRITE,
        ST_DONE
    } cfgb_state_e;

endpackage

// File: rtl/cfgb_addr_port.sv
module cfgb_addr_port
    import cfgb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DWORD_W-1:0]   load_data,
    output logic [DWORD_W-1:0]   addr_q,
    output logic                 enable,
    output logic [BUS_W-1:0]     bus,
    output logic [DEV_W-1:0]     dev,
    output logic [FN_W-1:0]      func,
    output logic [REG_W-1:0]     regno,
    output logic                 type1
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_data;
        end
    end

    assign enable = addr_q[EN_BIT];
    assign bus    = addr_q[BUS_LSB +: BUS_W];
    assign dev    = addr_q[DEV_LSB +: DEV_W];
    assign func   = addr_q[FN_LSB  +: FN_W];
    assign regno  = {addr_q[REG_LSB+OFF_W +: REG_W-OFF_W], {OFF_W{1'b0}}};
    assign type1  = |bus;

    // R1: the stored word moves only on a load
    p_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_q));

endmodule

// File: rtl/cfgb_lane_xform.sv
module cfgb_lane_xform
    import cfgb_pkg::*;
(
    input  logic [DWORD_W-1:0] dev_word,
    input  logic [DWORD_W-1:0] cpu_wdata,
    input  logic [OFF_W-1:0]   off,
    input  logic [1:0]         size,
    output logic [DWORD_W-1:0] rd_view,
    output logic [DWORD_W-1:0] wr_merge,
    output logic [LANES-1:0]   wr_be
);

    logic [7:0]       rot [LANES];
    logic [OFF_W:0]   nbytes;

    always_comb begin
        unique case (size)
            2'd0:    nbytes = (OFF_W+1)'(1);
            2'd1:    nbytes = (OFF_W+1)'(2);
            default: nbytes = (OFF_W+1)'(LANES);
        endcase
    end

    for (genvar gi = 0; gi < LANES; gi++) begin : g_rot
        logic [OFF_W-1:0] src;
        assign src     = OFF_W'(gi) + off;
        assign rot[gi] = dev_word[8*src +: 8];
    end

    always_comb begin
        unique case (size)
            2'd0:    rd_view = {24'd0, rot[0]};
            2'd1:    rd_view = {16'd0, rot[0], rot[1]};
            default: rd_view = {rot[0], rot[1], rot[2], rot[3]};
        endcase
    end

    for (genvar gj = 0; gj < LANES; gj++) begin : g_merge
        logic [OFF_W-1:0] rel;
        logic [OFF_W:0]   pick;
        logic             hit;
        assign rel  = OFF_W'(gj) - off;
        assign hit  = ({1'b0, rel} < nbytes);
        assign pick = nbytes - (OFF_W+1)'(1) - {1'b0, rel};
        assign wr_be[gj] = hit;
        assign wr_merge[8*gj +: 8] = hit ? cpu_wdata[8*pick[OFF_W-1:0] +: 8]
                                         : dev_word[8*gj +: 8];
    end

endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
    import cfgb_pkg::*;
#(
    parameter logic [DWORD_W-1:0] ABSENT_VALUE = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_data_sel,
    input  logic                 cpu_write,
    input  logic [OFF_W-1:0]     cpu_offset,
    input  logic [1:0]           cpu_size,
    input  logic                 enable,
    input  logic                 present,
    input  logic [DWORD_W-1:0]   addr_word,
    input  logic [DWORD_W-1:0]   rd_view,
    input  logic [DWORD_W-1:0]   wr_merge,
    output logic                 load_addr,
    output logic                 cpu_ready,
    output logic [DWORD_W-1:0]   cpu_rdata,
    output logic                 cfg_rd,
    output logic                 cfg_wr,
    output logic [DWORD_W-1:0]   cfg_wdata
);

    cfgb_state_e       state_q, state_d;
    logic [DWORD_W-1:0] rdata_q, wbuf_q;
    logic               full_write;
    logic               accept;

    assign full_write = cpu_write && cpu_size[1] && (cpu_offset == '0);
    assign accept     = (state_q == ST_IDLE) && cpu_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!cpu_data_sel || !enable || !present) state_d = ST_DONE;
                    else if (full_write)                      state_d = ST_WRITE;
                    else                                      state_d = ST_READ;
                end
            end
            ST_READ:    state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = cpu_write ? ST_WRITE : ST_DONE;
            ST_WRITE:   state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            wbuf_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                if (!cpu_data_sel)  rdata_q <= addr_word;
                else if (!enable)   rdata_q <= '0;
                else if (!present)  rdata_q <= ABSENT_VALUE;
                if (full_write)     wbuf_q  <= wr_merge;
            end else if (state_q == ST_CAPTURE) begin
                if (cpu_write) wbuf_q  <= wr_merge;
                else           rdata_q <= rd_view;
            end
        end
    end

    always_comb begin
        load_addr = accept && !cpu_data_sel && cpu_write;
        cpu_ready = (state_q == ST_DONE);
        cfg_rd    = (state_q == ST_READ);
        cfg_wr    = (state_q == ST_WRITE);
        cpu_rdata = rdata_q;
        cfg_wdata = wbuf_q;
    end

    // R9: strobes never overlap
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_rd && cfg_wr));
    // R9: ready is a single-cycle pulse
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    // R2: no write strobe while the enable bit is clear
    p_wr_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> enable);
    // R10: no write strobe to an absent device
    p_wr_needs_dev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> present);
    // R7: aligned full write strobes in the next cycle
    p_fast_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_data_sel && enable && present && full_write) |=> cfg_wr);
    // R8: read of a read-modify-write is followed by its write-back
    p_rmw_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cpu_write) |=> ##1 cfg_wr);

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
    import cfgb_pkg::*;
#(
    parameter logic [31:0] ABSENT_VALUE = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_data_sel,
    input  logic        cpu_write,
    input  logic [1:0]  cpu_offset,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_ready,
    output logic [7:0]  cfg_bus,
    output logic [4:0]  cfg_dev,
    output logic [2:0]  cfg_func,
    output logic [7:0]  cfg_reg,
    output logic [3:0]  cfg_be,
    output logic        cfg_type1,
    output logic        cfg_rd,
    output logic        cfg_wr,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_present,
    input  logic [31:0] cfg_rdata
);

    logic [DWORD_W-1:0] addr_word, rd_view, wr_merge;
    logic [LANES-1:0]   wr_be;
    logic               enable, load_addr;

    cfgb_addr_port u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_addr),
        .load_data (cpu_wdata),
        .addr_q    (addr_word),
        .enable    (enable),
        .bus       (cfg_bus),
        .dev       (cfg_dev),
        .func      (cfg_func),
        .regno     (cfg_reg),
        .type1     (cfg_type1)
    );

    cfgb_lane_xform u_xform (
        .dev_word  (cfg_rdata),
        .cpu_wdata (cpu_wdata),
        .off       (cpu_offset),
        .size      (cpu_size),
        .rd_view   (rd_view),
        .wr_merge  (wr_merge),
        .wr_be     (wr_be)
    );

    cfgb_ctrl #(.ABSENT_VALUE(ABSENT_VALUE)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_data_sel (cpu_data_sel),
        .cpu_write    (cpu_write),
        .cpu_offset   (cpu_offset),
        .cpu_size     (cpu_size),
        .enable       (enable),
        .present      (cfg_present),
        .addr_word    (addr_word),
        .rd_view      (rd_view),
        .wr_merge     (wr_merge),
        .load_addr    (load_addr),
        .cpu_ready    (cpu_ready),
        .cpu_rdata    (cpu_rdata),
        .cfg_rd       (cfg_rd),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata)
    );

    assign cfg_be = cfg_wr ? wr_be : {LANES{1'b1}};

endmodule

// File: tb/sim_cfg_access_bridge.sv
module sim_cfg_access_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_data_sel = 1'b0, cpu_write = 1'b0;
    logic [1:0]  cpu_offset = '0, cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic [7:0]  cfg_bus, cfg_reg;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [3:0]  cfg_be;
    logic        cfg_type1, cfg_rd, cfg_wr, cfg_present;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    logic [31:0] m_addr = '0;
    logic [31:0] tmem [logic [21:0]];

    always #5 clk = ~clk;

    function automatic bit tpresent(logic [7:0] b, logic [4:0] d, logic [2:0] f);
        return (b == 8'd0 && (d == 5'd0 || d == 5'd1 || d == 5'd3)) ||
               (b == 8'd2 && d == 5'd5 && f == 3'd1);
    endfunction

    function automatic logic [31:0] tget(logic [21:0] k);
        if (tmem.exists(k)) return tmem[k];
        return (32'(k) * 32'h0100_0193) ^ 32'hC0DE_5A17;
    endfunction

    function automatic int nbytes_of(logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_read(logic [31:0] d, logic [1:0] off, logic [1:0] sz);
        logic [31:0] r = '0;
        for (int i = 0; i < nbytes_of(sz); i++)
            r = (r << 8) | 32'(d[8*((int'(off)+i)%4) +: 8]);
        return r;
    endfunction

    function automatic logic [31:0] exp_merge(logic [31:0] old, logic [31:0] w,
                                              logic [1:0] off, logic [1:0] sz);
        logic [31:0] r = old;
        int n = nbytes_of(sz);
        for (int i = 0; i < n; i++)
            r[8*((int'(off)+i)%4) +: 8] = w[8*(n-1-i) +: 8];
        return r;
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] off, logic [1:0] sz);
        logic [3:0] r = '0;
        for (int i = 0; i < nbytes_of(sz); i++) r[(int'(off)+i)%4] = 1'b1;
        return r;
    endfunction

    assign cfg_present = tpresent(cfg_bus, cfg_dev, cfg_func);

    // Downstream target: data one cycle after the read strobe
    always @(posedge clk) begin
        if (cfg_rd) cfg_rdata <= tget({cfg_bus, cfg_dev, cfg_func, cfg_reg[7:2]});
        if (cfg_wr) tmem[{cfg_bus, cfg_dev, cfg_func, cfg_reg[7:2]}] = cfg_wdata;
    end

    cfg_access_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_data_sel(cpu_data_sel),
        .cpu_write(cpu_write), .cpu_offset(cpu_offset), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_reg(cfg_reg),
        .cfg_be(cfg_be), .cfg_type1(cfg_type1), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_present(cfg_present), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", rq, act, exp, $time);
        end
    endtask

    // One access; called at a negedge, returns at a negedge
    task automatic access(bit d, bit w, logic [1:0] off, logic [1:0] sz,
                          logic [31:0] wd, string rq);
        int          seq[$];
        logic [7:0]  b  = m_addr[15:8];
        logic [4:0]  dv = m_addr[23:19];
        logic [2:0]  fn = m_addr[18:16];
        logic [7:0]  rg = {m_addr[31:26], 2'b00};
        logic [21:0] key = {m_addr[15:8], m_addr[23:19], m_addr[18:16], m_addr[31:26]};
        logic [31:0] old = tget(key);
        logic [31:0] e_rd = '0, e_wd = '0;
        logic [3:0]  e_be = exp_be(off, sz);
        bit full = (sz >= 2'd2) && (off == 2'd0);
        if (!d) begin
            seq = '{4};
            e_rd = m_addr;
        end else if (!m_addr[7]) begin
            seq = '{4};
        end else if (!tpresent(b, dv, fn)) begin
            seq = '{4};
            e_rd = 32'hFFFF_FFFF;
        end else if (!w) begin
            seq = '{1, 0, 4};
            e_rd = exp_read(old, off, sz);
        end else if (full) begin
            seq = '{2, 4};
            e_wd = exp_merge(32'h0, wd, 2'd0, 2'd2);
        end else begin
            seq = '{1, 0, 2, 4};
            e_wd = exp_merge(old, wd, off, sz);
        end
        cpu_req = 1'b1; cpu_data_sel = d; cpu_write = w;
        cpu_offset = off; cpu_size = sz; cpu_wdata = wd;
        foreach (seq[i]) begin
            @(negedge clk);
            chk({cpu_ready, cfg_wr, cfg_rd} == 3'(seq[i]), {rq, " R9 strobes"},
                {29'd0, cpu_ready, cfg_wr, cfg_rd}, 32'(seq[i]));
            if (seq[i] != 4 && seq[i] != 0) begin
                chk({cfg_bus, cfg_dev, cfg_func, cfg_reg} == {b, dv, fn, rg},
                    {rq, " R3 fields"}, {8'd0, cfg_bus, cfg_dev, cfg_func, cfg_reg},
                    {8'd0, b, dv, fn, rg});
                chk(cfg_type1 == (b != 8'd0), {rq, " R4 type"}, 32'(cfg_type1), 32'(b != 8'd0));
            end
            if (seq[i] == 2) begin
                chk(cfg_wdata == e_wd, {rq, " write data"}, cfg_wdata, e_wd);
                chk(cfg_be == (full ? 4'hF : e_be), {rq, " R8 byte enables"},
                    32'(cfg_be), 32'(full ? 4'hF : e_be));
            end
            if (seq[i] == 1)
                chk(cfg_be == 4'hF, {rq, " R8 read enables"}, 32'(cfg_be), 32'hF);
            if (seq[i] == 4 && !w)
                chk(cpu_rdata == e_rd, {rq, " read data"}, cpu_rdata, e_rd);
        end
        cpu_req = 1'b0;
        if (!d && w) m_addr = wd;
        @(negedge clk);
        chk({cpu_ready, cfg_wr, cfg_rd} == 3'b000, {rq, " R9 idle after"},
            {29'd0, cpu_ready, cfg_wr, cfg_rd}, 32'd0);
    endtask

    function automatic logic [31:0] aw(logic [7:0] rg, logic [4:0] dv, logic [2:0] fn,
                                       logic [7:0] b, bit en);
        return {rg, dv, fn, b, en, 7'd0};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk({cpu_ready, cfg_rd, cfg_wr} == 3'b000, "R11 reset outputs",
            {29'd0, cpu_ready, cfg_rd, cfg_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        access(0, 0, 2'd0, 2'd2, 32'h0, "R11 reset address word");
        access(0, 1, 2'd0, 2'd2, 32'h1234_5678, "R1 address write");
        access(0, 0, 2'd0, 2'd2, 32'h0, "R1 address readback");
        // enable clear, present device
        access(0, 1, 2'd0, 2'd2, aw(8'h10, 5'd1, 3'd0, 8'd0, 0), "R2 set addr");
        access(1, 0, 2'd0, 2'd2, 32'h0, "R2 disabled read");
        access(1, 1, 2'd0, 2'd2, 32'hDEAD_BEEF, "R2 disabled write");
        access(0, 1, 2'd0, 2'd2, aw(8'h13, 5'd1, 3'd0, 8'd0, 1), "R3 set addr");
        access(1, 0, 2'd0, 2'd2, 32'h0, "R2 dword untouched");
        for (int o = 0; o < 4; o++) access(1, 0, 2'(o), 2'd0, 32'h0, "R6 byte read");
        for (int o = 0; o < 4; o++) access(1, 0, 2'(o), 2'd1, 32'h0, "R6 half read");
        access(1, 0, 2'd2, 2'd2, 32'h0, "R6 wrapped dword read");
        access(1, 1, 2'd0, 2'd2, 32'hAABB_CCDD, "R7 aligned write");
        access(1, 0, 2'd0, 2'd2, 32'h0, "R7 readback");
        access(1, 1, 2'd0, 2'd3, 32'h0102_0304, "R7 size 3 write");
        access(1, 0, 2'd0, 2'd3, 32'h0, "R7 size 3 readback");
        access(1, 1, 2'd2, 2'd0, 32'h0000_0077, "R8 byte write");
        access(1, 1, 2'd1, 2'd1, 32'h0000_9A8B, "R8 half write");
        access(1, 1, 2'd3, 2'd1, 32'h0000_E1F2, "R8 wrapped half write");
        access(1, 1, 2'd1, 2'd2, 32'h5566_7788, "R8 unaligned dword write");
        access(1, 0, 2'd0, 2'd2, 32'h0, "R8 readback");
        // type-1 target, register offset low bits dropped
        access(0, 1, 2'd0, 2'd2, aw(8'hFF, 5'd5, 3'd1, 8'd2, 1), "R4 set addr");
        access(1, 0, 2'd0, 2'd2, 32'h0, "R4 type1 read");
        access(1, 1, 2'd0, 2'd0, 32'h0000_0042, "R4 type1 byte write");
        access(1, 0, 2'd3, 2'd0, 32'h0, "R4 type1 readback");
        // absent devices
        access(0, 1, 2'd0, 2'd2, aw(8'h04, 5'd7, 3'd0, 8'd0, 1), "R5 set addr");
        access(1, 0, 2'd1, 2'd0, 32'h0, "R5 absent read");
        access(1, 1, 2'd0, 2'd2, 32'h1111_2222, "R10 absent full write");
        access(1, 1, 2'd1, 2'd0, 32'h0000_0033, "R10 absent byte write");
        access(0, 1, 2'd0, 2'd2, aw(8'h04, 5'd5, 3'd0, 8'd2, 1), "R5 set addr fn0");
        access(1, 0, 2'd0, 2'd2, 32'h0, "R5 absent type1 read");
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule